// File: doc/BRIEF.md
# GPIO Expander Pin Controller

This block holds the per-pin register bank and pin-control logic of an eight-pin general-purpose I/O expander. A serial front end outside the block turns bus transactions into simple register accesses: an address, a write strobe with write data, and a read strobe that returns read data one cycle later. Software uses these registers to set, for each pin, the direction, the level driven, a high-impedance override, the pull resistor and its polarity, the expected idle input level, and whether the pin may raise an interrupt.

From those settings the block drives, for every pad, separate enables for the high-side and low-side drivers, pull-up and pull-down enables, and an input-buffer enable. Pad inputs pass through a synchronizer. Their levels are captured in an input status register, and any input pin whose level differs from its programmed idle level latches a sticky interrupt status bit. The unmasked status bits merge into a single active-low interrupt line. Reading the interrupt status register clears it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset all pins are inputs (direction 0xFF), drive level 0x00, high-Z override 0xFF, pull enable 0xFF, pull polarity 0x00 (pull-down), idle level 0x00, mask 0xFF, input status 0x00 and interrupt status 0x00. So after reset drv_hi = drv_lo = pull_up_en = 0x00, pull_dn_en = ibuf_en = 0xFF and irq_n = 1.
- R2: Register addresses are 0 direction (1 = input, 0 = output), 1 drive level, 2 high-Z override, 3 pull enable, 4 pull polarity (1 = up, 0 = down), 5 idle level, 6 interrupt mask (1 = masked), 7 input status, 8 interrupt status. A read strobe returns the addressed register on rd_data one cycle later. Addresses 9 to 15 read as 0.
- R3: A pin with direction 1 has both drivers off and its input buffer enabled.
- R4: A pin with direction 0 and high-Z bit 0 enables exactly one driver: high when its drive-level bit is 1, low when it is 0. Its input buffer is disabled.
- R5: A set high-Z bit turns off both drivers of an output pin, whatever its drive-level bit.
- R6: pull_up_en is pull enable AND pull polarity, and pull_dn_en is pull enable AND NOT pull polarity, for each pin. The two are never both active on a pin.
- R7: Pad inputs pass through a two-flop synchronizer. The input status bit of an input pin follows the synchronized level. The bit of an output pin holds its last value.
- R8: An interrupt status bit sets when its pin is an input and the synchronized level differs from the idle-level bit. It stays set until interrupt status is read, and that read clears it. Output pins never set it.
- R9: irq_n is low exactly when some interrupt status bit is set with its mask bit 0. A pin change reaches irq_n on the fourth rising edge after it.
- R10: Writes to addresses 7 and 8 change no register.
- R11: Pin-control outputs are registered and reflect a register write one clock after the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after reg_rd |
| pin_in | input | 8 | Pad input levels |
| drv_hi | output | 8 | High-side driver enable per pin |
| drv_lo | output | 8 | Low-side driver enable per pin |
| pull_up_en | output | 8 | Pull-up enable per pin |
| pull_dn_en | output | 8 | Pull-down enable per pin |
| ibuf_en | output | 8 | Input-buffer enable per pin |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The hardest case to reach is a status bit that was latched while its mismatch was present and must stay set after the pin returns to its idle level. The interrupt line must stay low until a read, and it must rise only after a second read finds the pin at its idle level again. Directed sequences unmask one pin, toggle it, restore it and read twice, timing each read against the synchronizer delay. A further sequence counts edges from a pin change to irq_n falling. Random configuration writes and pad patterns, some to the read-only addresses, cover the driver, pull and input-status mapping against a bench model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR     = 4'd0,
    RA_LEVEL   = 4'd1,
    RA_HIZ     = 4'd2,
    RA_PULLEN  = 4'd3,
    RA_PULLSEL = 4'd4,
    RA_IDLE    = 4'd5,
    RA_MASK    = 4'd6,
    RA_INSTAT  = 4'd7,
    RA_IRQSTAT = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  level_q,
  output logic [NPINS-1:0]  hiz_q,
  output logic [NPINS-1:0]  pullen_q,
  output logic [NPINS-1:0]  pullsel_q,
  output logic [NPINS-1:0]  idle_q,
  output logic [NPINS-1:0]  mask_q
);
  localparam logic [NPINS-1:0] ALL1 = '1;
  localparam logic [NPINS-1:0] ALL0 = '0;

  reg_addr_e sel;
  assign sel = reg_addr_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= ALL1;
      level_q   <= ALL0;
      hiz_q     <= ALL1;
      pullen_q  <= ALL1;
      pullsel_q <= ALL0;
      idle_q    <= ALL0;
      mask_q    <= ALL1;
    end else if (wr_en) begin
      case (sel)
        RA_DIR:     dir_q     <= wr_data;
        RA_LEVEL:   level_q   <= wr_data;
        RA_HIZ:     hiz_q     <= wr_data;
        RA_PULLEN:  pullen_q  <= wr_data;
        RA_PULLSEL: pullsel_q <= wr_data;
        RA_IDLE:    idle_q    <= wr_data;
        RA_MASK:    mask_q    <= wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] level,
  input  logic [NPINS-1:0] hiz,
  input  logic [NPINS-1:0] pullen,
  input  logic [NPINS-1:0] pullsel,
  output logic [NPINS-1:0] drv_hi,
  output logic [NPINS-1:0] drv_lo,
  output logic [NPINS-1:0] pull_up_en,
  output logic [NPINS-1:0] pull_dn_en,
  output logic [NPINS-1:0] ibuf_en
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic drive_ok;
    assign drive_ok = ~dir[p] & ~hiz[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        drv_hi[p]     <= 1'b0;
        drv_lo[p]     <= 1'b0;
        pull_up_en[p] <= 1'b0;
        pull_dn_en[p] <= 1'b1;
        ibuf_en[p]    <= 1'b1;
      end else begin
        drv_hi[p]     <= drive_ok & level[p];
        drv_lo[p]     <= drive_ok & ~level[p];
        pull_up_en[p] <= pullen[p] & pullsel[p];
        pull_dn_en[p] <= pullen[p] & ~pullsel[p];
        ibuf_en[p]    <= dir[p];
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_logic.sv
module gpio_irq_logic #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] sync_in,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] idle,
  input  logic [NPINS-1:0] mask,
  input  logic             stat_clr,
  output logic [NPINS-1:0] in_stat,
  output logic [NPINS-1:0] irq_stat,
  output logic             irq_n
);
  logic [NPINS-1:0] mismatch;
  logic [NPINS-1:0] kept;

  assign mismatch = dir & (sync_in ^ idle);
  assign kept     = stat_clr ? '0 : irq_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_stat  <= '0;
      irq_stat <= '0;
      irq_n    <= 1'b1;
    end else begin
      in_stat  <= (in_stat & ~dir) | (sync_in & dir);
      irq_stat <= kept | mismatch;
      irq_n    <= ~|(irq_stat & ~mask);
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [NPINS-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [NPINS-1:0]  rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  drv_hi,
  output logic [NPINS-1:0]  drv_lo,
  output logic [NPINS-1:0]  pull_up_en,
  output logic [NPINS-1:0]  pull_dn_en,
  output logic [NPINS-1:0]  ibuf_en,
  output logic              irq_n
);
  logic [NPINS-1:0] dir_q, level_q, hiz_q, pullen_q, pullsel_q, idle_q, mask_q;
  logic [NPINS-1:0] pin_sync, in_stat, irq_stat;
  logic             stat_clr;
  reg_addr_e        rsel;

  assign rsel     = reg_addr_e'(reg_addr);
  assign stat_clr = reg_rd && (rsel == RA_IRQSTAT);

  gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .dir_q(dir_q), .level_q(level_q), .hiz_q(hiz_q), .pullen_q(pullen_q),
    .pullsel_q(pullsel_q), .idle_q(idle_q), .mask_q(mask_q)
  );

  gpio_pin_ctrl #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst(rst), .dir(dir_q), .level(level_q), .hiz(hiz_q),
    .pullen(pullen_q), .pullsel(pullsel_q), .drv_hi(drv_hi), .drv_lo(drv_lo),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .ibuf_en(ibuf_en)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_irq_logic #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst(rst), .sync_in(pin_sync), .dir(dir_q), .idle(idle_q),
    .mask(mask_q), .stat_clr(stat_clr), .in_stat(in_stat), .irq_stat(irq_stat),
    .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (reg_rd) begin
      case (rsel)
        RA_DIR:     rd_data <= dir_q;
        RA_LEVEL:   rd_data <= level_q;
        RA_HIZ:     rd_data <= hiz_q;
        RA_PULLEN:  rd_data <= pullen_q;
        RA_PULLSEL: rd_data <= pullsel_q;
        RA_IDLE:    rd_data <= idle_q;
        RA_MASK:    rd_data <= mask_q;
        RA_INSTAT:  rd_data <= in_stat;
        RA_IRQSTAT: rd_data <= irq_stat;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] drv_hi,
  input logic [NPINS-1:0] drv_lo,
  input logic [NPINS-1:0] pull_up_en,
  input logic [NPINS-1:0] pull_dn_en,
  input logic [NPINS-1:0] ibuf_en,
  input logic             irq_n,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] irq_stat,
  input logic             stat_clr
);
  // R4
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_hi & drv_lo) == '0);

  // R3
  ibuf_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ibuf_en & (drv_hi | drv_lo)) == '0);

  // R6
  one_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_up_en & pull_dn_en) == '0);

  // R9
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> irq_n);

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_clr |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .drv_hi(drv_hi), .drv_lo(drv_lo),
  .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en), .ibuf_en(ibuf_en),
  .irq_n(irq_n), .mask_q(mask_q), .irq_stat(irq_stat), .stat_clr(stat_clr)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = '0;
  logic [7:0] drv_hi, drv_lo, pull_up_en, pull_dn_en, ibuf_en;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_dir, m_lvl, m_hiz, m_pen, m_psel, m_idle, m_mask, m_in;

  always #2 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .rd_data(rd_data), .pin_in(pin_in),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .pull_up_en(pull_up_en),
    .pull_dn_en(pull_dn_en), .ibuf_en(ibuf_en), .irq_n(irq_n)
  );

  function automatic logic [7:0] f_hi(input logic [7:0] d, h, l);
    return ~d & ~h & l;
  endfunction
  function automatic logic [7:0] f_lo(input logic [7:0] d, h, l);
    return ~d & ~h & ~l;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    case (a)
      4'd0: m_dir = d;  4'd1: m_lvl = d;  4'd2: m_hiz = d;  4'd3: m_pen = d;
      4'd4: m_psel = d; 4'd5: m_idle = d; 4'd6: m_mask = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pin_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_dir = 8'hFF; m_lvl = 8'h00; m_hiz = 8'hFF; m_pen = 8'hFF;
    m_psel = 8'h00; m_idle = 8'h00; m_mask = 8'hFF; m_in = 8'h00;
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " R4 drv_hi"}, drv_hi, f_hi(m_dir, m_hiz, m_lvl));
    chk({tag, " R4 drv_lo"}, drv_lo, f_lo(m_dir, m_hiz, m_lvl));
    chk({tag, " R6 pull_up"}, pull_up_en, m_pen & m_psel);
    chk({tag, " R6 pull_dn"}, pull_dn_en, m_pen & ~m_psel);
    chk({tag, " R3 ibuf"}, ibuf_en, m_dir);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd7211));
    do_reset();
    @(negedge clk);
    // R1 reset state
    check_pins("R1 reset");
    chk("R1 irq_n", irq_n, 1);
    rd(4'd0, v); chk("R1 R2 dir read", v, 8'hFF);
    rd(4'd2, v); chk("R1 R2 hiz read", v, 8'hFF);
    rd(4'd6, v); chk("R1 R2 mask read", v, 8'hFF);
    rd(4'd8, v); chk("R1 irqstat read", v, 8'h00);
    rd(4'd12, v); chk("R2 unused address", v, 8'h00);

    // R11 one-cycle update after write
    @(negedge clk); reg_addr = 4'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R11 not yet updated", ibuf_en, 8'hFF);
    @(negedge clk);
    chk("R11 updated", ibuf_en, 8'h00);
    m_dir = 8'h00;

    // Random configuration and pad patterns
    for (int i = 0; i < 150; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 8));
      d = 8'($urandom);
      wr(a, d);
      @(negedge clk); pin_in = 8'($urandom);
      m_in = (m_in & ~m_dir) | (pin_in & m_dir);
      repeat (5) @(negedge clk);
      check_pins("rand R5");
      rd(4'd7, v); chk("rand R7 R10 in_stat", v, m_in);
      rd(a, v);
      if (a <= 4'd6) begin
        case (a)
          4'd0: chk("rand R2 dir", v, m_dir);
          4'd1: chk("rand R2 level", v, m_lvl);
          4'd2: chk("rand R2 hiz", v, m_hiz);
          4'd3: chk("rand R2 pullen", v, m_pen);
          4'd4: chk("rand R2 pullsel", v, m_psel);
          4'd5: chk("rand R2 idle", v, m_idle);
          default: chk("rand R2 mask", v, m_mask);
        endcase
      end
    end

    // Directed: high-Z override
    do_reset();
    wr(4'd0, 8'hFE); wr(4'd1, 8'h01);
    @(negedge clk);
    chk("R5 hiz blocks drive hi", drv_hi, 8'h00);
    wr(4'd2, 8'hFE); @(negedge clk);
    chk("R4 drive hi", drv_hi, 8'h01);
    wr(4'd1, 8'h00); @(negedge clk);
    chk("R4 drive lo", drv_lo, 8'h01);
    chk("R4 drive hi off", drv_hi, 8'h00);
    wr(4'd4, 8'h0F); wr(4'd3, 8'h3C); @(negedge clk);
    chk("R6 up", pull_up_en, 8'h0C);
    chk("R6 dn", pull_dn_en, 8'h30);

    // Directed: masked then unmasked interrupt
    do_reset();
    @(negedge clk); pin_in = 8'h08;
    repeat (6) @(negedge clk);
    chk("R9 masked irq quiet", irq_n, 1);
    rd(4'd8, v); chk("R8 status set", v, 8'h08);
    wr(4'd6, 8'hF7);
    repeat (3) @(negedge clk);
    chk("R9 unmasked irq low", irq_n, 0);
    @(negedge clk); pin_in = 8'h00;
    repeat (6) @(negedge clk);
    chk("R8 sticky irq still low", irq_n, 0);
    rd(4'd8, v); chk("R8 sticky status", v, 8'h08);
    rd(4'd8, v); chk("R8 cleared by read", v, 8'h00);
    repeat (2) @(negedge clk);
    chk("R9 irq released", irq_n, 1);

    // Directed: idle level compare
    wr(4'd5, 8'h20); repeat (4) @(negedge clk);
    rd(4'd8, v); chk("R8 idle-level mismatch", v, 8'h20);
    wr(4'd5, 8'h00); repeat (4) @(negedge clk);
    rd(4'd8, v); rd(4'd8, v); chk("R8 idle match clear", v, 8'h00);

    // Directed: output pin ignored by input path
    wr(4'd0, 8'hBF);
    @(negedge clk); pin_in = 8'h40;
    repeat (6) @(negedge clk);
    rd(4'd8, v); chk("R8 output pin no status", v, 8'h00);
    rd(4'd7, v); chk("R7 output pin holds", v, 8'h00);
    chk("R4 ibuf off", ibuf_en, 8'hBF);
    @(negedge clk); pin_in = 8'h00;
    wr(4'd0, 8'hFF);

    // Directed: read-only addresses
    wr(4'd7, 8'hAA);
    @(negedge clk); pin_in = 8'h11;
    repeat (6) @(negedge clk);
    rd(4'd7, v); chk("R10 R7 in_stat follows pad", v, 8'h11);
    @(negedge clk); pin_in = 8'h00;
    repeat (6) @(negedge clk);
    rd(4'd8, v); rd(4'd8, v);
    wr(4'd8, 8'hFF); @(negedge clk);
    rd(4'd8, v); chk("R10 irqstat write ignored", v, 8'h00);
    rd(4'd0, v); chk("R10 dir intact", v, 8'hFF);

    // Directed: synchronizer latency to irq_n
    wr(4'd6, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 idle before edge", irq_n, 1);
    @(negedge clk); pin_in = 8'h01;
    repeat (3) @(negedge clk);
    chk("R7 R9 irq after 3 edges", irq_n, 1);
    @(negedge clk);
    chk("R7 R9 irq after 4 edges", irq_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule